// File: doc/BRIEF.md
# Table-Mapped Clock Divider with Source Select

This block divides a clock that is carried as a one-cycle enable ("tick") in a common clock domain. A 3-bit code picks the division ratio N from an eight-entry table. The table is not a linear function of the code, and codes 0 and 1 can give the same ratio. Each instance chooses one of four table profiles through a parameter. Both even and odd ratios are produced. The output is a level that stays high for floor(N/2) source ticks and low for the rest of the period. A one-cycle strobe marks the start of each period.

An optional front-end selector picks one of three candidate tick streams. A gate input stops the divider. A new ratio code or a new source takes effect only at the end of the output period in progress, so a change never shortens or stretches a pulse.

Top module: `cdiv_top`

## Requirements
- R1: During and after synchronous reset `div_clk` and `div_stb` are 0. The active ratio is the profile's entry for code 0 and the active source is 0.
- R2: The ratio N for `ratio_sel` codes 0..7 depends on `PROFILE`. PROF_NET (0) gives 4,4,6,8,10,12,14,16. PROF_GEN (1) gives 4,8,12,16,20,24,28,32. PROF_ENG (2) gives 2,2,3,4,5,6,7,8. PROF_LEG (3) gives 2,4,6,8,10,12,14,16.
- R3: Within each period `div_clk` is high for floor(N/2) ticks of the active source and low for the remaining N - floor(N/2) ticks. The period begins with its high part.
- R4: A change of `ratio_sel` while the divider runs takes effect only after the last tick of the current period.
- R5: With `HAS_MUX`=1, `src_sel` codes 0, 1 and 2 select `src_tick` bit 0, 1 and 2. A change of source is adopted at a period boundary.
- R6: `src_sel` code 3 is reserved and keeps the previously active source.
- R7: While `gate_en` is 0 the period counter is cleared and `div_clk` is 0 from the next cycle. The current codes are loaded continuously. The first tick after `gate_en` returns to 1 starts a new period with its high part.
- R8: `div_stb` is 1 for exactly one cycle, in the cycle in which `div_clk` rises.
- R9: Cycles without a tick on the active source leave the divider unchanged. Ticks on unselected sources have no effect.
- R10: With `HAS_MUX`=0 the divider always counts `src_tick` bit 0 and ignores `src_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst | input | 1 | Synchronous reset, active high |
| src_tick | input | 3 | One-cycle enables of the three candidate source clocks |
| src_sel | input | 2 | Source code (0..2 valid, 3 reserved) |
| ratio_sel | input | 3 | Ratio table code |
| gate_en | input | 1 | Divider run enable |
| div_clk | output | 1 | Divided clock level |
| div_stb | output | 1 | Strobe in the cycle of each rising edge of div_clk |

## Verification
The bench measures the high and low run lengths for every code on all four profiles. This catches a design that skips the duplicated entry at codes 0/1, or that rounds the odd-ratio duty the wrong way (high for ceil(N/2)). It changes the ratio in the middle of a period: a design that loads the code at once would cut the current high phase short and emit a runt. It also drives the reserved source code and ticks on the unselected sources, where a faulty selector shows up as a changed strobe rate. Finally it stops and restarts the gate, where a design that keeps its count would resume mid-period, or start low instead of high.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

    typedef enum logic [1:0] {
        PROF_NET = 2'd0,
        PROF_GEN = 2'd1,
        PROF_ENG = 2'd2,
        PROF_LEG = 2'd3
    } profile_e;

    localparam int NUM_SRC   = 3;
    localparam int SEL_W     = 2;
    localparam int CODE_W    = 3;
    localparam int MAX_RATIO = 32;
    localparam int RATIO_W   = $clog2(MAX_RATIO + 1);

    typedef logic [RATIO_W-1:0] ratio_t;
    typedef logic [SEL_W-1:0]   src_t;

    typedef struct packed {
        ratio_t n;
        ratio_t half;
    } ratio_cfg_t;

    function automatic ratio_t ratio_of(profile_e prof, logic [CODE_W-1:0] code);
        ratio_t k;
        k = ratio_t'(code) + ratio_t'(1);
        case (prof)
            PROF_NET: ratio_of = (code < 3'd2) ? ratio_t'(4) : ratio_t'(k << 1);
            PROF_GEN: ratio_of = ratio_t'(k << 2);
            PROF_ENG: ratio_of = (code < 3'd2) ? ratio_t'(2) : k;
            default:  ratio_of = ratio_t'(k << 1);
        endcase
    endfunction

endpackage

// File: rtl/cdiv_ratio_map.sv
module cdiv_ratio_map
    import cdiv_pkg::*;
#(
    parameter profile_e PROFILE = PROF_ENG
) (
    input  logic [CODE_W-1:0] code,
    output ratio_cfg_t        cfg
);

    always_comb begin
        cfg.n    = ratio_of(PROFILE, code);
        cfg.half = cfg.n >> 1;
    end

    always_comb begin
        AST_RATIO_MIN: assert (cfg.n >= ratio_t'(2) && cfg.half >= ratio_t'(1)); // R2
    end

endmodule

// File: rtl/cdiv_src_sel.sv
module cdiv_src_sel
    import cdiv_pkg::*;
#(
    parameter bit HAS_MUX = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  src_t               src_sel,
    input  logic [NUM_SRC-1:0] src_tick,
    output logic               tick,
    output src_t               src_act
);

    generate
        if (HAS_MUX) begin : g_mux
            src_t act_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    act_q <= '0;
                end else if (load && src_sel != src_t'(3)) begin
                    act_q <= src_sel;
                end
            end

            always_comb begin
                case (act_q)
                    src_t'(1): tick = src_tick[1];
                    src_t'(2): tick = src_tick[2];
                    default:   tick = src_tick[0];
                endcase
            end

            assign src_act = act_q;

            AST_SRC_VALID: assert property (@(posedge clk) disable iff (rst)
                act_q != src_t'(3)); // R6
            AST_SRC_RSV: assert property (@(posedge clk) disable iff (rst)
                (src_sel == src_t'(3)) |=> $stable(act_q)); // R6
            AST_SRC_HOLD: assert property (@(posedge clk) disable iff (rst)
                !load |=> $stable(act_q)); // R5
        end else begin : g_fixed
            logic unused_inputs;
            assign unused_inputs = ^{clk, rst, load, src_sel, src_tick[NUM_SRC-1:1]};
            assign tick    = src_tick[0];
            assign src_act = '0;
        end
    endgenerate

endmodule

// File: rtl/cdiv_phase_ctr.sv
module cdiv_phase_ctr
    import cdiv_pkg::*;
#(
    parameter profile_e PROFILE = PROF_ENG
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       gate_en,
    input  logic       tick,
    input  ratio_cfg_t cfg_next,
    output logic       load,
    output logic       div_clk,
    output logic       div_stb
);

    localparam ratio_t RST_N = ratio_of(PROFILE, '0);

    ratio_t cnt_q;
    ratio_t n_act_q;
    ratio_t half_act_q;
    logic   clk_q;
    logic   stb_q;
    logic   last_tick;

    assign last_tick = tick && (cnt_q == n_act_q - ratio_t'(1));
    assign load      = !gate_en || last_tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            n_act_q    <= RST_N;
            half_act_q <= RST_N >> 1;
            clk_q      <= 1'b0;
            stb_q      <= 1'b0;
        end else begin
            stb_q <= 1'b0;
            if (!gate_en) begin
                cnt_q      <= '0;
                clk_q      <= 1'b0;
                n_act_q    <= cfg_next.n;
                half_act_q <= cfg_next.half;
            end else if (tick) begin
                stb_q <= (cnt_q == '0);
                clk_q <= (cnt_q < half_act_q);
                if (last_tick) begin
                    cnt_q      <= '0;
                    n_act_q    <= cfg_next.n;
                    half_act_q <= cfg_next.half;
                end else begin
                    cnt_q <= cnt_q + ratio_t'(1);
                end
            end
        end
    end

    assign div_clk = clk_q;
    assign div_stb = stb_q;

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q < n_act_q); // R3
    AST_GATE_LOW: assert property (@(posedge clk) disable iff (rst)
        !gate_en |=> !div_clk); // R7
    AST_STB_RISE: assert property (@(posedge clk) disable iff (rst)
        div_stb |-> (div_clk && !$past(div_clk))); // R8
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (gate_en && !tick) |=> ($stable(cnt_q) && $stable(div_clk))); // R9
    AST_RATIO_STABLE: assert property (@(posedge clk) disable iff (rst)
        (gate_en && !last_tick) |=> $stable(n_act_q)); // R4

endmodule

// File: rtl/cdiv_top.sv
module cdiv_top
    import cdiv_pkg::*;
#(
    parameter profile_e PROFILE = PROF_ENG,
    parameter bit       HAS_MUX = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic [SEL_W-1:0]   src_sel,
    input  logic [CODE_W-1:0]  ratio_sel,
    input  logic               gate_en,
    output logic               div_clk,
    output logic               div_stb
);

    ratio_cfg_t cfg_next;
    logic       load;
    logic       tick;
    src_t       src_act;
    logic       unused_act;

    assign unused_act = ^src_act;

    cdiv_ratio_map #(.PROFILE(PROFILE)) u_map (
        .code (ratio_sel),
        .cfg  (cfg_next)
    );

    cdiv_src_sel #(.HAS_MUX(HAS_MUX)) u_src (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .src_sel  (src_sel),
        .src_tick (src_tick),
        .tick     (tick),
        .src_act  (src_act)
    );

    cdiv_phase_ctr #(.PROFILE(PROFILE)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .gate_en  (gate_en),
        .tick     (tick),
        .cfg_next (cfg_next),
        .load     (load),
        .div_clk  (div_clk),
        .div_stb  (div_stb)
    );

    AST_RST_LOW: assert property (@(posedge clk)
        rst |=> (!div_clk && !div_stb)); // R1

endmodule

// File: tb/sim_cdiv_top.sv
module sim_cdiv_top;
    import cdiv_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] src_tick;
    logic [1:0] src_sel = 2'd0;
    logic [2:0] ratio_sel = 3'd0;
    logic       gate_en = 1'b0;
    logic [3:0] dclk;
    logic [3:0] dstb;

    int per [3] = '{1, 1, 1};
    int cyc = 0;
    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) cyc <= cyc + 1;

    always_comb begin
        for (int i = 0; i < 3; i++)
            src_tick[i] = (per[i] != 0) && ((cyc % per[i]) == 0);
    end

    cdiv_top #(.PROFILE(PROF_ENG), .HAS_MUX(1'b1)) u0 (
        .clk(clk), .rst(rst), .src_tick(src_tick), .src_sel(src_sel),
        .ratio_sel(ratio_sel), .gate_en(gate_en), .div_clk(dclk[0]), .div_stb(dstb[0]));
    cdiv_top #(.PROFILE(PROF_NET), .HAS_MUX(1'b0)) u1 (
        .clk(clk), .rst(rst), .src_tick(src_tick), .src_sel(src_sel),
        .ratio_sel(ratio_sel), .gate_en(gate_en), .div_clk(dclk[1]), .div_stb(dstb[1]));
    cdiv_top #(.PROFILE(PROF_GEN), .HAS_MUX(1'b1)) u2 (
        .clk(clk), .rst(rst), .src_tick(src_tick), .src_sel(src_sel),
        .ratio_sel(ratio_sel), .gate_en(gate_en), .div_clk(dclk[2]), .div_stb(dstb[2]));
    cdiv_top #(.PROFILE(PROF_LEG), .HAS_MUX(1'b1)) u3 (
        .clk(clk), .rst(rst), .src_tick(src_tick), .src_sel(src_sel),
        .ratio_sel(ratio_sel), .gate_en(gate_en), .div_clk(dclk[3]), .div_stb(dstb[3]));

    function automatic int exp_n(int inst, int code);
        int eng [8] = '{2, 2, 3, 4, 5, 6, 7, 8};
        int net [8] = '{4, 4, 6, 8, 10, 12, 14, 16};
        int gen [8] = '{4, 8, 12, 16, 20, 24, 28, 32};
        int leg [8] = '{2, 4, 6, 8, 10, 12, 14, 16};
        case (inst)
            0: return eng[code];
            1: return net[code];
            2: return gen[code];
            default: return leg[code];
        endcase
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic stop_and_load(int rs, int ss);
        gate_en   = 1'b0;
        ratio_sel = 3'(rs);
        src_sel   = 2'(ss);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic count_stb(int ncyc, output int c0, output int c1);
        c0 = 0; c1 = 0;
        for (int k = 0; k < ncyc; k++) begin
            @(negedge clk);
            c0 += dstb[0];
            c1 += dstb[1];
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 div_clk in reset", dclk, 0);
        chk("R1 div_stb in reset", dstb, 0);
        rst = 1'b0;
        gate_en = 1'b1;
        @(negedge clk);
        // code 0 after reset: ENG N=2 -> first tick drives high
        chk("R1 first tick high", dclk[0], 1);
        @(negedge clk);
        chk("R1 ENG ratio 2 second tick low", dclk[0], 0);
    endtask

    task automatic t_profiles();
        per = '{1, 1, 1};
        for (int code = 0; code < 8; code++) begin
            int hi [4];
            int lo [4];
            int ph [4];
            stop_and_load(code, 0);
            for (int u = 0; u < 4; u++) begin hi[u] = 0; lo[u] = 0; ph[u] = 0; end
            gate_en = 1'b1;
            for (int k = 0; k < 70; k++) begin
                @(negedge clk);
                for (int u = 0; u < 4; u++) begin
                    if (ph[u] == 0) begin
                        if (dclk[u]) hi[u]++; else begin lo[u]++; ph[u] = 1; end
                    end else if (ph[u] == 1) begin
                        if (dclk[u]) ph[u] = 2; else lo[u]++;
                    end
                end
            end
            for (int u = 0; u < 4; u++) begin
                int n = exp_n(u, code);
                chk($sformatf("R2/R3 high run inst%0d code%0d", u, code), hi[u], n / 2);
                chk($sformatf("R2/R3 low run inst%0d code%0d", u, code), lo[u], n - n / 2);
            end
        end
    endtask

    task automatic t_ratio_change();
        logic [13:0] got_c;
        logic [13:0] got_s;
        per = '{1, 1, 1};
        stop_and_load(7, 0);
        gate_en = 1'b1;
        for (int k = 0; k < 14; k++) begin
            @(negedge clk);
            got_c[13-k] = dclk[0];
            got_s[13-k] = dstb[0];
            if (k == 1) ratio_sel = 3'd2;
        end
        // R4: period of 8 completes, then N=3 periods
        chk("R4 output sequence across ratio change", int'(got_c), int'(14'b11110000_100100));
        chk("R8 strobe only at rising edges", int'(got_s), int'(14'b10000000_100100));
    endtask

    task automatic t_source();
        int a, b;
        per = '{1, 2, 1};
        stop_and_load(3, 1);
        gate_en = 1'b1;
        count_stb(64, a, b);
        chk("R5 source 1 selected, N=4 over 2-cycle ticks", a, 8);
        chk("R9 other sources ignored", a, 8);
        chk("R10 no-mux instance counts bit 0", b, 8);
        src_sel = 2'd3;
        count_stb(64, a, b);
        chk("R6 reserved code keeps source 1", a, 8);
        src_sel = 2'd2;
        count_stb(16, a, b);
        count_stb(64, a, b);
        chk("R5 source 2 adopted", a, 16);
        src_sel = 2'd1;
        per = '{0, 2, 1};
        count_stb(16, a, b);
        count_stb(64, a, b);
        chk("R10 no-mux instance ignores src_sel", b, 0);
    endtask

    task automatic t_gate();
        int low_bad;
        int stb_cnt;
        logic [2:0] seq;
        per = '{1, 1, 1};
        stop_and_load(3, 0);
        gate_en = 1'b1;
        repeat (5) @(negedge clk);
        gate_en = 1'b0;
        ratio_sel = 3'd0;
        low_bad = 0;
        stb_cnt = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            low_bad += dclk[0];
            stb_cnt += dstb[0];
        end
        chk("R7 output low while gated", low_bad, 0);
        chk("R7 no strobe while gated", stb_cnt, 0);
        gate_en = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            seq[2-k] = dclk[0];
        end
        chk("R7 restart at period start with new ratio", int'(seq), int'(3'b101));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_profiles();
        t_ratio_change();
        t_source();
        t_gate();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule